// File: doc/BRIEF.md
# One-Entry Posted Write Buffer

This block sits between a processor-side request port and a synchronous dual-port RAM. A write request does not go to the RAM right away. Its address and data are parked in a single pending slot. The slot reaches the RAM only when the next write request displaces it, or when the flush input drains it. As a result, RAM writes always trail the processor's writes by one request.

A read first compares its address with the pending slot. On a match, the parked data is returned and the RAM is left untouched. On a miss, a RAM read is issued in the same cycle, and the RAM's registered output is passed back one cycle later. Both kinds of read answer one cycle after the request, and each answer is marked by a response-valid pulse.

Top module: `posted_write_buffer`

## Requirements
- R1: While reset is low, and in the first cycle after it, the slot is empty, `rsp_valid` is 0 and `ram_we` is 0.
- R2: A write accepted while the slot is empty drives `ram_we` low in that cycle, and the new address and data are parked in the slot.
- R3: A write accepted while the slot is full raises `ram_we` in the same cycle, with `ram_waddr`/`ram_wdata` equal to the previously parked entry. The new entry replaces it. `ram_we` is never high in a cycle without a write or a flush.
- R4: A read (`req_valid`=1, `req_we`=0) whose address equals the parked address while the slot is full keeps `ram_re` low. One cycle later it returns the parked data.
- R5: A read that misses the slot raises `ram_re` in the same cycle, with `ram_raddr` equal to the request address. One cycle later it returns `ram_rdata`.
- R6: `rsp_valid` is 1 in exactly the cycles that follow an accepted read.
- R7: `flush` with a full slot and no write in that cycle commits the parked entry to the RAM in that cycle and empties the slot. `flush` with an empty slot drives `ram_we` low.
- R8: A write to the address already parked commits the old value and then holds the new one. Later reads of that address return the newest value.
- R9: When `flush` and a write arrive in the same cycle, the write behaviour of R2/R3 applies. The slot ends up full and holds the new entry.
- R10: Every read returns the most recently written value for its address, with or without flushes in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request word address |
| req_wdata | input | DW | Write data |
| flush | input | 1 | Drain the pending slot to RAM |
| rsp_valid | output | 1 | Read data valid (one cycle after read) |
| rsp_rdata | output | DW | Read data |
| ram_we | output | 1 | RAM write strobe |
| ram_waddr | output | AW | RAM write address |
| ram_wdata | output | DW | RAM write data |
| ram_re | output | 1 | RAM read strobe |
| ram_raddr | output | AW | RAM read address |
| ram_rdata | input | DW | RAM registered read data |

## Verification
The hardest case to reach is a read that hits the pending slot right after a same-address overwrite or in the same cycle as a flush. In both cases the stale RAM word and the newer parked word differ. The directed phase builds these cases explicitly. A random phase then confines addresses to eight words and mixes in frequent flushes, so hits, overwrites and drains occur densely against a reference memory.

// File: rtl/pwb_pkg.sv
// Shared definitions for the posted write buffer.
// Assumes at most one request per cycle on the processor port.
package pwb_pkg;
    typedef enum logic [1:0] {
        PWB_IDLE  = 2'd0,
        PWB_READ  = 2'd1,
        PWB_WRITE = 2'd2
    } pwb_op_e;

    // Classify a processor request.
    function automatic pwb_op_e pwb_decode(input logic valid, input logic we);
        if (!valid)  return PWB_IDLE;
        else if (we) return PWB_WRITE;
        else         return PWB_READ;
    endfunction
endpackage

// File: rtl/pwb_slot.sv
// Single pending-write slot. A load displaces any held entry through the
// commit outputs. A drain commits the held entry and empties the slot.
// Assumes load takes priority over drain in the same cycle.
module pwb_slot #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic          drain,
    output logic          held,
    output logic [AW-1:0] held_addr,
    output logic [DW-1:0] held_data,
    output logic          commit
);
    // Commit whenever a held entry is displaced or drained.
    always_comb begin
        commit = held && (load || drain);
    end

    // Slot state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held      <= 1'b0;
            held_addr <= '0;
            held_data <= '0;
        end else if (load) begin
            held      <= 1'b1;
            held_addr <= load_addr;
            held_data <= load_data;
        end else if (drain) begin
            held      <= 1'b0;
        end
    end
endmodule

// File: rtl/pwb_read_path.sv
// Read side: compares a read against the pending slot, issues RAM reads on
// a miss, and aligns hit and miss answers to a one-cycle latency.
// Assumes the RAM returns registered data one cycle after ram_re.
module pwb_read_path #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic          held,
    input  logic [AW-1:0] held_addr,
    input  logic [DW-1:0] held_data,
    input  logic [DW-1:0] ram_rdata,
    output logic          ram_re,
    output logic [AW-1:0] ram_raddr,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);
    logic          hit;
    logic          hit_q;
    logic [DW-1:0] fwd_q;

    // Address match against the pending slot.
    always_comb begin
        hit       = rd_req && held && (rd_addr == held_addr);
        ram_re    = rd_req && !hit;
        ram_raddr = rd_addr;
    end

    // Register response flags and forwarded data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            hit_q     <= 1'b0;
            fwd_q     <= '0;
        end else begin
            rsp_valid <= rd_req;
            hit_q     <= hit;
            if (hit) fwd_q <= held_data;
        end
    end

    // Select forwarded data or RAM output.
    always_comb begin
        rsp_rdata = hit_q ? fwd_q : ram_rdata;
    end
endmodule

// File: rtl/posted_write_buffer.sv
// One-entry posted write buffer between a processor port and a dual-port
// synchronous RAM. Writes land in RAM one write request late; reads are
// forwarded from the pending slot on address match.
// Assumes one request per cycle; flush alongside a write is absorbed.
module posted_write_buffer #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          flush,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          ram_we,
    output logic [AW-1:0] ram_waddr,
    output logic [DW-1:0] ram_wdata,
    output logic          ram_re,
    output logic [AW-1:0] ram_raddr,
    input  logic [DW-1:0] ram_rdata
);
    import pwb_pkg::*;

    pwb_op_e       op;
    logic          is_wr;
    logic          is_rd;
    logic          held;
    logic [AW-1:0] held_addr;
    logic [DW-1:0] held_data;
    logic          commit;

    // Decode the incoming request.
    always_comb begin
        op    = pwb_decode(req_valid, req_we);
        is_wr = (op == PWB_WRITE);
        is_rd = (op == PWB_READ);
    end

    pwb_slot #(.AW(AW), .DW(DW)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (is_wr),
        .load_addr (req_addr),
        .load_data (req_wdata),
        .drain     (flush),
        .held      (held),
        .held_addr (held_addr),
        .held_data (held_data),
        .commit    (commit)
    );

    pwb_read_path #(.AW(AW), .DW(DW)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (is_rd),
        .rd_addr   (req_addr),
        .held      (held),
        .held_addr (held_addr),
        .held_data (held_data),
        .ram_rdata (ram_rdata),
        .ram_re    (ram_re),
        .ram_raddr (ram_raddr),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // Drive the RAM write port from the slot's commit.
    always_comb begin
        ram_we    = commit;
        ram_waddr = held_addr;
        ram_wdata = held_data;
    end
endmodule

// File: rtl/pwb_checker.sv
// Property checker for posted_write_buffer, attached by bind.
module pwb_checker #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_we,
    input logic [AW-1:0] req_addr,
    input logic [DW-1:0] req_wdata,
    input logic          flush,
    input logic          rsp_valid,
    input logic          ram_we,
    input logic          ram_re,
    input logic [AW-1:0] ram_raddr,
    input logic          held,
    input logic [AW-1:0] held_addr,
    input logic [DW-1:0] held_data
);
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (!held && !rsp_valid));

    assert_empty_no_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !held |-> !ram_we);

    assert_commit_needs_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ((req_valid && req_we) || flush));

    assert_hit_skips_ram_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_we && held && req_addr == held_addr) |-> !ram_re);

    assert_miss_reads_ram_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_we && !(held && req_addr == held_addr))
            |-> (ram_re && ram_raddr == req_addr));

    assert_rsp_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_we) |=> rsp_valid);

    assert_no_stray_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_we) |=> !rsp_valid);

    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !(req_valid && req_we)) |=> !held);

    assert_write_parks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we) |=> (held && held_addr == $past(req_addr)
                                   && held_data == $past(req_wdata)));
endmodule

bind posted_write_buffer pwb_checker #(.AW(AW), .DW(DW)) u_pwb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .flush     (flush),
    .rsp_valid (rsp_valid),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .ram_raddr (ram_raddr),
    .held      (held),
    .held_addr (held_addr),
    .held_data (held_data)
);

// File: tb/posted_write_buffer_test.sv
module posted_write_buffer_test;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          flush = 1'b0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          ram_we;
    logic [AW-1:0] ram_waddr;
    logic [DW-1:0] ram_wdata;
    logic          ram_re;
    logic [AW-1:0] ram_raddr;
    logic [DW-1:0] ram_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural models: bench RAM, reference memory, pending-write view.
    logic [DW-1:0] bram [NW];
    int            ref_mem [NW];
    bit            pv;
    int            pa, pd;
    int            exp_q [$];

    always #2 clk = ~clk;

    posted_write_buffer #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .flush(flush),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_we(ram_we),
        .ram_waddr(ram_waddr), .ram_wdata(ram_wdata), .ram_re(ram_re),
        .ram_raddr(ram_raddr), .ram_rdata(ram_rdata)
    );

    // Synchronous RAM with registered read.
    always @(posedge clk) begin
        if (ram_we) bram[ram_waddr] <= ram_wdata;
        if (ram_re) ram_rdata <= bram[ram_raddr];
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check RAM port, clock, check response.
    task automatic step(input bit v, input bit we, input int a, input int d, input bit fl);
        bit is_w, is_r, hit, exp_we;
        int ea, ed;
        is_w = v && we;
        is_r = v && !we;
        hit  = is_r && pv && (pa == a);
        exp_we = pv && (is_w || fl);
        ea = pa; ed = pd;
        req_valid = v; req_we = we; req_addr = a[AW-1:0];
        req_wdata = d[DW-1:0]; flush = fl;
        #1;
        chk(is_w ? "R3 ram_we on write" : "R7 ram_we on flush/idle", int'(ram_we), int'(exp_we));
        if (exp_we) begin
            chk("R3 commit addr", int'(ram_waddr), ea);
            chk("R3 commit data", int'(ram_wdata), ed);
        end
        if (v && !we) begin
            chk(hit ? "R4 no RAM read on hit" : "R5 RAM read on miss", int'(ram_re), int'(!hit));
            if (!hit) chk("R5 ram_raddr", int'(ram_raddr), a);
        end
        @(posedge clk);
        if (is_w) begin
            ref_mem[a] = d;
            pv = 1; pa = a; pd = d;
        end else if (fl) pv = 0;
        if (is_r) exp_q.push_back(ref_mem[a]);
        @(negedge clk);
        chk("R6 rsp_valid", int'(rsp_valid), int'(is_r));
        if (is_r && exp_q.size() > 0) begin
            int e;
            e = exp_q.pop_front();
            chk("R10 read value", int'(rsp_rdata), e);
        end
    endtask

    initial begin
        #40000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) begin bram[i] = '0; ref_mem[i] = 0; end
        pv = 0; pa = 0; pd = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rsp_valid in reset", int'(rsp_valid), 0);
        chk("R1 ram_we in reset", int'(ram_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
        // R7 flush on empty slot has no effect
        step(0, 0, 0, 0, 1);
        // R2 first write commits nothing
        step(1, 1, 5, 16'h1111, 0);
        chk("R2 RAM untouched", int'(bram[5]), 0);
        // R4 hit forwards pending data
        step(1, 0, 5, 0, 0);
        // R3 second write commits first
        step(1, 1, 9, 16'h2222, 0);
        step(0, 0, 0, 0, 0);
        chk("R3 RAM holds first write", int'(bram[5]), 16'h1111);
        // R5 miss reads RAM
        step(1, 0, 5, 0, 0);
        // R8 same-address overwrite
        step(1, 1, 9, 16'h3333, 0);
        step(1, 0, 9, 0, 0);
        step(1, 1, 7, 16'h4444, 0);
        step(1, 0, 9, 0, 0);
        // R10 read with flush same cycle (hit forwarded while draining)
        step(1, 0, 7, 0, 1);
        step(1, 0, 7, 0, 0);
        chk("R7 RAM drained", int'(bram[7]), 16'h4444);
        // R9 flush with write: slot stays full
        step(1, 1, 3, 16'h5555, 1);
        step(1, 1, 3, 16'h6666, 1);
        step(1, 0, 3, 0, 0);
        step(0, 0, 0, 0, 1);
        chk("R9 latest drained", int'(bram[3]), 16'h6666);
        // Random mix over eight words
        for (int n = 0; n < 3000; n++) begin
            int r, a;
            r = $urandom_range(0, 9);
            a = $urandom_range(0, 7);
            if (r < 4)      step(1, 1, a, $urandom_range(0, 65535), r == 0);
            else if (r < 8) step(1, 0, a, 0, r == 4);
            else            step(0, 0, 0, 0, r == 8);
        end
        step(0, 0, 0, 0, 1);
        for (int i = 0; i < 8; i++) chk("R10 final RAM image", int'(bram[i]), ref_mem[i]);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule